// File: doc/BRIEF.md
# Four-channel DMA host register file

This block is the host-side register file of a four-channel, legacy-style DMA controller. Software reaches it over a narrow I/O bus: a 4-bit offset, separate write and read strobes, and an 8-bit data path in each direction. For each channel it keeps a 16-bit base address and a 16-bit base count, plus working (current) copies of both. It also holds the per-channel mask bits, a 6-bit mode per channel, a command byte, the software request bits and the terminal-count status bits. All of these values go out to a separate transfer engine.

Every host register is one byte wide. Each 16-bit address or count is therefore moved through a single port in two accesses, low byte first and then high byte. A two-state byte-pointer machine chooses the byte. Its states are `PTR_LO` and `PTR_HI`:

- The transition `toggle` fires on every access to an address or count port, in either direction.
- The transition `clear` forces `PTR_LO`. It is taken on a write to the clear-pointer port or the master-clear port, and on reset.

The transfer engine may rewrite the current address and count of a channel. It may report terminal counts. The count value stored is the number of transfers minus one, so 0xFFFF stands for 65536 transfers and 0x0000 for one. The block stores and exports this value unchanged.

Top module: `xfer_chan_regs`

## Requirements
- R1: After reset, the following hold:
  - The byte pointer is low.
  - The masks are 4'b1111.
  - Command, request bits, terminal-count bits, all addresses, all counts, all modes and `io_rdata` are zero.
- R2: Offsets 2n and 2n+1 (n = 0..3) are the address port and the count port of channel n.
  - A write to either port loads the byte chosen by the pointer into both the base copy and the current copy.
  - The low byte is bits [7:0]; the high byte is bits [15:8].
- R3: The byte pointer behaves as follows:
  - Every read or write of offsets 0..7 toggles the byte pointer.
  - Any write to offset 0xC returns the pointer to the low byte.
  - Accesses to any other offset leave it unchanged.
- R4: A read of an address or count port returns the byte of the current address or current count chosen by the pointer. `io_rdata` presents it from the clock edge that samples `io_rd`.
- R5: A write to offset 0xA uses data bits [1:0] as the channel number. Bit 2 set masks that channel; bit 2 clear unmasks it. Other channels are unchanged.
- R6: A write to offset 0xF loads the four mask bits from data bits [3:0]. Any write to offset 0xE clears all four mask bits.
- R7: A write to offset 0xB stores data bits [7:2] as the mode of the channel named by bits [1:0]. The other modes are unchanged.
- R8: Writes to offsets 0x8 and 0x9 behave as follows:
  - A write to offset 0x8 stores the command byte.
  - A write to offset 0x9 sets the request bit of channel [1:0] when bit 2 is 1, and clears it when bit 2 is 0.
  - A read of offset 0x8 returns the status byte, {request[3:0], terminal-count[3:0]}.
- R9: The terminal-count bits behave as follows:
  - A pulse on `eng_tc[n]` sets terminal-count bit n.
  - A status read clears the bits that were set before it. It returns those bits.
  - A bit pulsed in the same cycle as the read stays set.
- R10: A write to offset 0xD is a master clear:
  - It returns the pointer to low.
  - It zeroes command, request and terminal-count bits.
  - It sets all masks.
  - Addresses, counts and modes keep their values.
- R11: When `eng_upd` is high, the current address and count of channel `eng_chan` take `eng_addr` and `eng_count`. The base copies keep their values. If the host writes a byte of that same register in the same cycle, that byte takes the host data and the other byte takes the engine value.
- R12: Reads of offsets 0x9 to 0xF return 0x00. They do not move the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_offs | input | 4 | Register offset |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered |
| eng_upd | input | 1 | Engine update of one channel's current address and count |
| eng_chan | input | 2 | Channel for the engine update |
| eng_addr | input | 16 | New current address |
| eng_count | input | 16 | New current count |
| eng_tc | input | 4 | Terminal-count pulses, one bit per channel |
| base_addr_o | output | 64 | Base addresses, channel n in bits [16n+15:16n] |
| base_count_o | output | 64 | Base counts, same packing |
| cur_addr_o | output | 64 | Current addresses, same packing |
| cur_count_o | output | 64 | Current counts, same packing |
| chan_mode_o | output | 24 | Modes, channel n in bits [6n+5:6n] |
| chan_mask_o | output | 4 | Mask bit per channel, 1 = masked |
| cmd_o | output | 8 | Command byte |
| sw_req_o | output | 4 | Software request bits |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a host byte write to a channel's address port and an engine update of that same channel. The bench drives both strobes on the same edge. It then checks three things:
- the current address holds the host byte in the lane chosen by the pointer and the engine byte in the other lane;
- the base copy changes only in the host lane;
- a later read returns the merged high byte.

The second pair is a status read and a new terminal-count pulse. The bench checks that the read returns the old bits and that the new bit survives into the next read.

// File: rtl/chreg_pkg.sv
package chreg_pkg;

    // Byte-pointer machine states
    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_state_e;

    // Offset width of the host bus; offsets 0..7 are the word ports
    localparam int OFS_W = 4;

    localparam logic [OFS_W-1:0] OFS_CMD     = 4'h8;  // write: command, read: status
    localparam logic [OFS_W-1:0] OFS_REQ     = 4'h9;
    localparam logic [OFS_W-1:0] OFS_SMASK   = 4'hA;
    localparam logic [OFS_W-1:0] OFS_MODE    = 4'hB;
    localparam logic [OFS_W-1:0] OFS_CLRPTR  = 4'hC;
    localparam logic [OFS_W-1:0] OFS_MCLR    = 4'hD;  // write: master clear, read: temp (0)
    localparam logic [OFS_W-1:0] OFS_CLRMASK = 4'hE;
    localparam logic [OFS_W-1:0] OFS_ALLMASK = 4'hF;

endpackage

// File: rtl/chreg_byte_ptr.sv
module chreg_byte_ptr
    import chreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic word_access,
    input  logic ptr_clear,
    output logic hi_sel
);

    ptr_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    // Transitions: clear wins, then toggle on each word-port access
    always_comb begin
        state_d = state_q;
        if (ptr_clear) begin
            state_d = PTR_LO;
        end else if (word_access) begin
            unique case (state_q)
                PTR_LO:  state_d = PTR_HI;
                PTR_HI:  state_d = PTR_LO;
                default: state_d = PTR_LO;
            endcase
        end
    end

    // Outputs
    always_comb begin
        hi_sel = (state_q == PTR_HI);
    end

    a_r3_clear_to_low: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clear |=> !hi_sel);

    a_r3_toggle_on_access: assert property (@(posedge clk) disable iff (!rst_n)
        (word_access && !ptr_clear) |=> (hi_sel != $past(hi_sel)));

    a_r12_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_access && !ptr_clear) |=> $stable(hi_sel));

endmodule

// File: rtl/chreg_chan_bank.sv
// Storage of one channel: base/current address and count.
// WORD_W is two bytes of DATA_W; hi_sel picks the byte lane.
module chreg_chan_bank #(
    parameter int DATA_W = 8,
    parameter int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              host_addr_we,
    input  logic              host_cnt_we,
    input  logic              eng_upd,
    input  logic [WORD_W-1:0] eng_addr,
    input  logic [WORD_W-1:0] eng_cnt,
    output logic [WORD_W-1:0] base_addr,
    output logic [WORD_W-1:0] base_cnt,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_cnt
);

    function automatic logic [WORD_W-1:0] put_byte(
        input logic [WORD_W-1:0] word,
        input logic              hi,
        input logic [DATA_W-1:0] b
    );
        logic [WORD_W-1:0] r;
        r = word;
        if (hi) r[WORD_W-1 -: DATA_W] = b;
        else    r[DATA_W-1:0]         = b;
        return r;
    endfunction

    logic [WORD_W-1:0] base_addr_d, base_cnt_d, cur_addr_d, cur_cnt_d;
    logic [WORD_W-1:0] cur_addr_pre, cur_cnt_pre;

    always_comb begin
        base_addr_d  = host_addr_we ? put_byte(base_addr, hi_sel, wdata) : base_addr;
        base_cnt_d   = host_cnt_we  ? put_byte(base_cnt,  hi_sel, wdata) : base_cnt;
        cur_addr_pre = eng_upd ? eng_addr : cur_addr;
        cur_cnt_pre  = eng_upd ? eng_cnt  : cur_cnt;
        cur_addr_d   = host_addr_we ? put_byte(cur_addr_pre, hi_sel, wdata) : cur_addr_pre;
        cur_cnt_d    = host_cnt_we  ? put_byte(cur_cnt_pre,  hi_sel, wdata) : cur_cnt_pre;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
        end else begin
            base_addr <= base_addr_d;
            base_cnt  <= base_cnt_d;
            cur_addr  <= cur_addr_d;
            cur_cnt   <= cur_cnt_d;
        end
    end

    a_r11_base_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_upd && !host_addr_we) |=> $stable(base_addr));

    a_r11_base_cnt_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_upd && !host_cnt_we) |=> $stable(base_cnt));

    a_r2_low_byte_mirrored: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr_we && !hi_sel) |=> (base_addr[DATA_W-1:0] == cur_addr[DATA_W-1:0]));

    a_r2_high_byte_mirrored: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cnt_we && hi_sel) |=> (base_cnt[WORD_W-1 -: DATA_W] == cur_cnt[WORD_W-1 -: DATA_W]));

endmodule

// File: rtl/chreg_ctrl_regs.sv
module chreg_ctrl_regs
    import chreg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int MODE_W = DATA_W - CH_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [OFS_W-1:0]         offs,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     status_rd,
    input  logic [NUM_CH-1:0]        eng_tc,
    output logic [NUM_CH-1:0]        mask,
    output logic [NUM_CH*MODE_W-1:0] mode,
    output logic [DATA_W-1:0]        cmd,
    output logic [NUM_CH-1:0]        req,
    output logic [NUM_CH-1:0]        tc
);

    logic              mclr;
    logic [CH_W-1:0]   sel_ch;
    logic [NUM_CH-1:0] mask_d, req_d, tc_d;
    logic [DATA_W-1:0] cmd_d;

    assign mclr   = wr_en && (offs == OFS_MCLR);
    assign sel_ch = wdata[CH_W-1:0];

    always_comb begin
        mask_d = mask;
        req_d  = req;
        cmd_d  = cmd;
        tc_d   = (status_rd ? '0 : tc) | eng_tc;
        if (mclr) begin
            mask_d = '1;
            req_d  = '0;
            cmd_d  = '0;
            tc_d   = '0;
        end else if (wr_en) begin
            unique case (offs)
                OFS_SMASK:   mask_d[sel_ch] = wdata[CH_W];
                OFS_CLRMASK: mask_d = '0;
                OFS_ALLMASK: mask_d = wdata[NUM_CH-1:0];
                OFS_REQ:     req_d[sel_ch] = wdata[CH_W];
                OFS_CMD:     cmd_d = wdata;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '1;
            req  <= '0;
            cmd  <= '0;
            tc   <= '0;
        end else begin
            mask <= mask_d;
            req  <= req_d;
            cmd  <= cmd_d;
            tc   <= tc_d;
        end
    end

    // Per-channel mode fields
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_mode
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode[ch*MODE_W +: MODE_W] <= '0;
            end else if (wr_en && (offs == OFS_MODE) && (sel_ch == CH_W'(ch))) begin
                mode[ch*MODE_W +: MODE_W] <= wdata[DATA_W-1:CH_W];
            end
        end
    end

    a_r10_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (mask == '1 && cmd == '0 && req == '0 && tc == '0));

    a_r6_clear_all_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offs == OFS_CLRMASK) |=> (mask == '0));

    a_r5_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offs == OFS_SMASK) |=> (mask[$past(sel_ch)] == $past(wdata[CH_W])));

    a_r9_tc_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((|eng_tc) && !mclr) |=> ((tc & $past(eng_tc)) == $past(eng_tc)));

    a_r9_tc_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && eng_tc == '0) |=> (tc == '0));

endmodule

// File: rtl/xfer_chan_regs.sv
// Offsets assume four channels: word ports at 0..7, control at 8..F.
module xfer_chan_regs
    import chreg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    localparam int WORD_W = 2 * DATA_W,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int MODE_W = DATA_W - CH_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [OFS_W-1:0]         io_offs,
    input  logic                     io_wr,
    input  logic                     io_rd,
    input  logic [DATA_W-1:0]        io_wdata,
    output logic [DATA_W-1:0]        io_rdata,
    input  logic                     eng_upd,
    input  logic [CH_W-1:0]          eng_chan,
    input  logic [WORD_W-1:0]        eng_addr,
    input  logic [WORD_W-1:0]        eng_count,
    input  logic [NUM_CH-1:0]        eng_tc,
    output logic [NUM_CH*WORD_W-1:0] base_addr_o,
    output logic [NUM_CH*WORD_W-1:0] base_count_o,
    output logic [NUM_CH*WORD_W-1:0] cur_addr_o,
    output logic [NUM_CH*WORD_W-1:0] cur_count_o,
    output logic [NUM_CH*MODE_W-1:0] chan_mode_o,
    output logic [NUM_CH-1:0]        chan_mask_o,
    output logic [DATA_W-1:0]        cmd_o,
    output logic [NUM_CH-1:0]        sw_req_o
);

    // Access decode; a write takes precedence over a read in the same cycle
    logic            wr_en, rd_en, is_word, word_access, ptr_clear, status_rd;
    logic [CH_W-1:0] word_ch;
    logic            word_is_cnt;
    logic            hi_sel;

    assign wr_en       = io_wr;
    assign rd_en       = io_rd && !io_wr;
    assign is_word     = !io_offs[OFS_W-1];
    assign word_ch     = io_offs[CH_W:1];
    assign word_is_cnt = io_offs[0];
    assign word_access = (wr_en || rd_en) && is_word;
    assign ptr_clear   = wr_en && ((io_offs == OFS_CLRPTR) || (io_offs == OFS_MCLR));
    assign status_rd   = rd_en && (io_offs == OFS_CMD);

    chreg_byte_ptr u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_access (word_access),
        .ptr_clear   (ptr_clear),
        .hi_sel      (hi_sel)
    );

    logic [WORD_W-1:0] cur_addr_a [NUM_CH];
    logic [WORD_W-1:0] cur_cnt_a  [NUM_CH];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic hit;
        logic [WORD_W-1:0] b_addr, b_cnt, c_addr, c_cnt;

        assign hit = wr_en && is_word && (word_ch == CH_W'(ch));

        chreg_chan_bank #(
            .DATA_W (DATA_W),
            .WORD_W (WORD_W)
        ) u_bank (
            .clk          (clk),
            .rst_n        (rst_n),
            .hi_sel       (hi_sel),
            .wdata        (io_wdata),
            .host_addr_we (hit && !word_is_cnt),
            .host_cnt_we  (hit && word_is_cnt),
            .eng_upd      (eng_upd && (eng_chan == CH_W'(ch))),
            .eng_addr     (eng_addr),
            .eng_cnt      (eng_count),
            .base_addr    (b_addr),
            .base_cnt     (b_cnt),
            .cur_addr     (c_addr),
            .cur_cnt      (c_cnt)
        );

        assign base_addr_o [ch*WORD_W +: WORD_W] = b_addr;
        assign base_count_o[ch*WORD_W +: WORD_W] = b_cnt;
        assign cur_addr_o  [ch*WORD_W +: WORD_W] = c_addr;
        assign cur_count_o [ch*WORD_W +: WORD_W] = c_cnt;
        assign cur_addr_a[ch] = c_addr;
        assign cur_cnt_a[ch]  = c_cnt;
    end

    logic [NUM_CH-1:0] tc_bits;

    chreg_ctrl_regs #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .offs      (io_offs),
        .wdata     (io_wdata),
        .status_rd (status_rd),
        .eng_tc    (eng_tc),
        .mask      (chan_mask_o),
        .mode      (chan_mode_o),
        .cmd       (cmd_o),
        .req       (sw_req_o),
        .tc        (tc_bits)
    );

    // Read multiplexer, registered
    logic [WORD_W-1:0] rd_word;
    logic [DATA_W-1:0] rd_byte;

    always_comb begin
        rd_word = word_is_cnt ? cur_cnt_a[word_ch] : cur_addr_a[word_ch];
        rd_byte = '0;
        if (is_word) begin
            rd_byte = hi_sel ? rd_word[WORD_W-1 -: DATA_W] : rd_word[DATA_W-1:0];
        end else if (io_offs == OFS_CMD) begin
            rd_byte = {sw_req_o, tc_bits};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     io_rdata <= '0;
        else if (rd_en) io_rdata <= rd_byte;
    end

    a_r12_temp_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && io_offs == OFS_MCLR) |=> (io_rdata == '0));

    a_r4_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(io_rdata));

endmodule

// File: tb/xfer_chan_regs_tb_top.sv
module xfer_chan_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  io_offs;
    logic        io_wr, io_rd;
    logic [7:0]  io_wdata, io_rdata;
    logic        eng_upd;
    logic [1:0]  eng_chan;
    logic [15:0] eng_addr, eng_count;
    logic [3:0]  eng_tc;
    logic [63:0] base_addr_o, base_count_o, cur_addr_o, cur_count_o;
    logic [23:0] chan_mode_o;
    logic [3:0]  chan_mask_o, sw_req_o;
    logic [7:0]  cmd_o;

    always #5 clk = ~clk;

    xfer_chan_regs dut_i (
        .clk(clk), .rst_n(rst_n), .io_offs(io_offs), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .eng_upd(eng_upd), .eng_chan(eng_chan),
        .eng_addr(eng_addr), .eng_count(eng_count), .eng_tc(eng_tc),
        .base_addr_o(base_addr_o), .base_count_o(base_count_o), .cur_addr_o(cur_addr_o),
        .cur_count_o(cur_count_o), .chan_mode_o(chan_mode_o), .chan_mask_o(chan_mask_o),
        .cmd_o(cmd_o), .sw_req_o(sw_req_o)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t rd_q[$];
    int  n_chk  = 0;
    int  n_fail = 0;
    logic rd_seen = 1'b0;
    bit  done = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] w16(input logic [63:0] v, input int ch);
        return v[ch*16 +: 16];
    endfunction

    task automatic io_write(input logic [3:0] o, input logic [7:0] d);
        @(negedge clk);
        io_offs = o; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // Driver: issues a read and pushes the expected byte to the scoreboard
    task automatic io_read(input logic [3:0] o, input logic [7:0] e, input string tag);
        rd_item_t it;
        @(negedge clk);
        io_offs = o; io_rd = 1'b1;
        it.exp = e; it.tag = tag;
        rd_q.push_back(it);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    // Monitor: a read sampled at a posedge is compared at the following negedge
    always @(posedge clk) rd_seen <= io_rd && !io_wr;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (rd_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R4: actual unexpected read %0h expected none", io_rdata);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                chk(it.tag, {56'd0, io_rdata}, {56'd0, it.exp});
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; io_offs = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
        eng_upd = 1'b0; eng_chan = '0; eng_addr = '0; eng_count = '0; eng_tc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 masks", {60'd0, chan_mask_o}, 64'hF);
        chk("R1 cmd", {56'd0, cmd_o}, 64'h0);
        chk("R1 req", {60'd0, sw_req_o}, 64'h0);
        chk("R1 base addr", base_addr_o, 64'h0);
        chk("R1 cur count", cur_count_o, 64'h0);
        chk("R1 modes", {40'd0, chan_mode_o}, 64'h0);
        chk("R1 rdata", {56'd0, io_rdata}, 64'h0);
        io_read(4'h8, 8'h00, "R1 status");

        // R2 word writes, low then high
        io_write(4'hC, 8'h00);
        io_write(4'h2, 8'h34); io_write(4'h2, 8'h12);
        io_write(4'h3, 8'hFF); io_write(4'h3, 8'hFF);
        io_write(4'h6, 8'hCD); io_write(4'h6, 8'hAB);
        chk("R2 ch1 base addr", {48'd0, w16(base_addr_o, 1)}, 64'h1234);
        chk("R2 ch1 cur addr", {48'd0, w16(cur_addr_o, 1)}, 64'h1234);
        chk("R2 ch1 base count", {48'd0, w16(base_count_o, 1)}, 64'hFFFF);
        chk("R2 ch3 base addr", {48'd0, w16(base_addr_o, 3)}, 64'hABCD);

        // R4 read back through the pointer
        io_read(4'h2, 8'h34, "R4 ch1 addr lo");
        io_read(4'h2, 8'h12, "R4 ch1 addr hi");
        io_read(4'h3, 8'hFF, "R4 ch1 count lo");
        io_read(4'h3, 8'hFF, "R4 ch1 count hi");

        // R3 pointer cleared mid-pair
        io_write(4'h0, 8'h11);
        io_write(4'hC, 8'h5A);
        io_write(4'h0, 8'h22); io_write(4'h0, 8'h33);
        chk("R3 ch0 addr after clear", {48'd0, w16(base_addr_o, 0)}, 64'h3322);

        // R12 control-port read does not move the pointer
        io_write(4'hC, 8'h00);
        io_write(4'h4, 8'h44);
        io_read(4'hA, 8'h00, "R12 read of write-only port");
        io_write(4'h4, 8'h55);
        chk("R12 ch2 addr pointer kept", {48'd0, w16(base_addr_o, 2)}, 64'h5544);

        // R5 / R6 masks
        io_write(4'hE, 8'h00);
        chk("R6 clear all", {60'd0, chan_mask_o}, 64'h0);
        io_write(4'hA, 8'h06);
        chk("R5 mask ch2", {60'd0, chan_mask_o}, 64'h4);
        io_write(4'hA, 8'h02);
        chk("R5 unmask ch2", {60'd0, chan_mask_o}, 64'h0);
        io_write(4'hF, 8'hFA);
        chk("R6 load all", {60'd0, chan_mask_o}, 64'hA);
        io_write(4'hA, 8'h04);
        chk("R5 mask ch0", {60'd0, chan_mask_o}, 64'hB);

        // R7 modes
        io_write(4'hB, 8'hA9);
        io_write(4'hB, 8'hFF);
        chk("R7 ch1 mode", {58'd0, chan_mode_o[6 +: 6]}, 64'h2A);
        chk("R7 ch3 mode", {58'd0, chan_mode_o[18 +: 6]}, 64'h3F);
        chk("R7 ch0 ch2 untouched", {52'd0, chan_mode_o[0 +: 6], chan_mode_o[12 +: 6]}, 64'h0);

        // R8 command and request
        io_write(4'h8, 8'h5A);
        chk("R8 cmd", {56'd0, cmd_o}, 64'h5A);
        io_write(4'h9, 8'h07);
        io_write(4'h9, 8'h05);
        chk("R8 req set", {60'd0, sw_req_o}, 64'hA);
        io_write(4'h9, 8'h03);
        io_write(4'h9, 8'h07);
        chk("R8 req clear then set", {60'd0, sw_req_o}, 64'hA);

        // R9 terminal count, including a pulse coinciding with the status read
        @(negedge clk); eng_tc = 4'b0011;
        @(negedge clk); eng_tc = 4'b0000;
        io_read(4'h8, 8'hA3, "R9 status with tc");
        begin
            rd_item_t it;
            @(negedge clk);
            io_offs = 4'h8; io_rd = 1'b1; eng_tc = 4'b0100;
            it.exp = 8'hA0; it.tag = "R9 status read clears, same-cycle pulse";
            rd_q.push_back(it);
            @(negedge clk);
            io_rd = 1'b0; eng_tc = 4'b0000;
        end
        io_read(4'h8, 8'hA4, "R9 same-cycle pulse kept");
        io_read(4'h8, 8'hA0, "R9 cleared after read");

        // R10 master clear with pointer left high
        io_write(4'h1, 8'h77);
        io_write(4'hD, 8'h00);
        chk("R10 masks set", {60'd0, chan_mask_o}, 64'hF);
        chk("R10 cmd zero", {56'd0, cmd_o}, 64'h0);
        chk("R10 req zero", {60'd0, sw_req_o}, 64'h0);
        chk("R10 addr kept", {48'd0, w16(base_addr_o, 1)}, 64'h1234);
        chk("R10 mode kept", {58'd0, chan_mode_o[6 +: 6]}, 64'h2A);
        io_read(4'h8, 8'h00, "R10 status zero");
        io_write(4'h1, 8'h88); io_write(4'h1, 8'h99);
        chk("R10 pointer low after clear", {48'd0, w16(base_count_o, 0)}, 64'h9988);
        io_read(4'hD, 8'h00, "R12 temp reads zero");

        // R11 engine update alone
        @(negedge clk);
        eng_upd = 1'b1; eng_chan = 2'd3; eng_addr = 16'h1357; eng_count = 16'h2468;
        @(negedge clk);
        eng_upd = 1'b0;
        chk("R11 cur addr", {48'd0, w16(cur_addr_o, 3)}, 64'h1357);
        chk("R11 cur count", {48'd0, w16(cur_count_o, 3)}, 64'h2468);
        chk("R11 base addr kept", {48'd0, w16(base_addr_o, 3)}, 64'hABCD);
        io_write(4'hC, 8'h00);
        io_read(4'h7, 8'h68, "R4 ch3 cur count lo");
        io_read(4'h7, 8'h24, "R4 ch3 cur count hi");

        // R11 engine update and host byte write in the same cycle (pointer low)
        @(negedge clk);
        eng_upd = 1'b1; eng_chan = 2'd2; eng_addr = 16'hBEEF; eng_count = 16'h0102;
        io_offs = 4'h4; io_wdata = 8'h66; io_wr = 1'b1;
        @(negedge clk);
        eng_upd = 1'b0; io_wr = 1'b0;
        chk("R11 merged cur addr", {48'd0, w16(cur_addr_o, 2)}, 64'hBE66);
        chk("R11 base addr host lane only", {48'd0, w16(base_addr_o, 2)}, 64'h5566);
        chk("R11 cur count engine", {48'd0, w16(cur_count_o, 2)}, 64'h0102);
        io_read(4'h4, 8'hBE, "R11 merged high byte");

        repeat (3) @(negedge clk);
        if (rd_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R4: actual %0d reads pending expected 0", rd_q.size());
        end
        done = 1;
        finish_run();
    end

endmodule